// File: doc/BRIEF.md
# Processor Clock-Stop Power State Controller

This block follows the low-power state of one processor core. It knows five states: normal execution, halt power-down, stop-grant, snoop service and sleep. The core moves between them on a halt pulse, on wake events, on an active-low stop-clock request, on an active-low sleep request and on snoop begin and end pulses. For each state the block reports whether snoops and interrupts may be serviced.

Stop-grant is not entered as soon as stop-clock falls. The block first holds its current state. It then waits for the acknowledge response of the stop-grant bus cycle, and enters stop-grant a fixed number of clocks after that response. Stop-clock may only be released once this core and its sibling logical processor have both reached stop-grant. Any release at another time raises a sticky protocol-violation flag. A snoop that interrupts halt power-down or stop-grant returns to the state it came from. A release of stop-grant also returns to its origin, which is normal or halt power-down.

Top module: `cpu_pwr_state_ctrl`

## Requirements
- R1: An active-low reset returns the block to normal (state code 1) at once, from any state, and clears the violation flag.
- R2: A halt pulse in normal moves the block to halt power-down (code 2).
- R3: In halt power-down, any bit of the 5-bit wake vector moves the block to normal. The bits are: bit0 init, bit1 bus-init, bit2 non-maskable interrupt, bit3 maskable interrupt, bit4 bus-delivered interrupt.
- R4: While stop-clock is low in normal or halt power-down, the block holds its state. An acknowledge response received while this request is active starts a wait. Stop-grant (code 3) is entered exactly GRANT_DELAY clocks after the cycle in which the response is sampled. A response that arrives while no request is active is ignored.
- R5: In stop-grant, a stop-clock release with the sibling-ready input high returns the block to the state it entered stop-grant from.
- R6: A snoop event in halt power-down or stop-grant enters snoop service (code 4). A snoop-done pulse returns the block to the state the snoop interrupted.
- R7: A stop-clock release in stop-grant while sibling-ready is low sets the violation flag and leaves the block in stop-grant.
- R8: A low sleep request in stop-grant enters sleep (code 5), and releasing it returns the block to stop-grant. Snoop events in sleep are ignored.
- R9: Snoops-allowed is high in codes 2, 3 and 4. Interrupts-allowed is high in codes 2 and 3 only.
- R10: Wake events in stop-grant or sleep are ignored and are not stored. After release to halt power-down the block stays there.
- R11: A stop-clock release during the wait, before stop-grant is reached, sets the violation flag. The wait is abandoned and the block stays in its origin state.
- R12: Once set, the violation flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_req_i | input | 1 | Pulse: halt executed and its bus cycle issued |
| wake_i | input | N_WAKE | Wake events (init, bus-init, NMI, INTR, bus interrupt) |
| stpclk_ni | input | 1 | Stop-clock request, active low |
| slp_ni | input | 1 | Sleep request, active low |
| snoop_evt_i | input | 1 | Pulse: snoop event arrives |
| snoop_done_i | input | 1 | Pulse: snoop serviced |
| sg_ack_rsp_i | input | 1 | Pulse: response phase of the stop-grant acknowledge cycle |
| sibling_sg_i | input | 1 | Sibling logical processor is in stop-grant |
| state_o | output | 3 | State code: 1 normal, 2 halt, 3 stop-grant, 4 snoop, 5 sleep |
| snoop_ok_o | output | 1 | Snoops may be serviced |
| irq_ok_o | output | 1 | Interrupts may be serviced |
| viol_o | output | 1 | Sticky protocol-violation flag |

## Verification
The bench builds the block with GRANT_DELAY set to 5. With this value the bench checks the stop-grant wait on every cycle, from the acknowledge response to the entry edge, and catches an entry that comes one cycle early or one cycle late. It sweeps every wake bit singly from halt power-down. It runs the stop-grant entry and release from both origins, and it drives each illegal release point: before the acknowledge, during the wait, in sleep, and with the sibling not ready.

// File: rtl/cpu_pwr_pkg.sv
package cpu_pwr_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL = 3'd1,
    ST_HALT   = 3'd2,
    ST_SG     = 3'd3,
    ST_SNOOP  = 3'd4,
    ST_SLEEP  = 3'd5
  } pwr_state_e;
endpackage

// File: rtl/pwr_grant_timer.sv
module pwr_grant_timer #(
  parameter int unsigned DELAY = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(DELAY + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(DELAY);
    end else if (busy_q) begin
      if (done_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  // R4
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !abort_i && !done_o |=> busy_q && (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R11
  abort_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !busy_q);
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import cpu_pwr_pkg::*;
#(
  parameter int unsigned N_WAKE = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_req_i,
  input  logic [N_WAKE-1:0] wake_i,
  input  logic              stpclk_ni,
  input  logic              slp_ni,
  input  logic              snoop_evt_i,
  input  logic              snoop_done_i,
  input  logic              sibling_sg_i,
  input  logic              grant_done_i,
  output pwr_state_e        state_o,
  output logic              stop_seq_o,
  output logic              abort_o,
  output logic              viol_o
);
  pwr_state_e state_q, state_d;
  pwr_state_e sg_org_q, sg_org_d;
  pwr_state_e snp_org_q, snp_org_d;
  logic       seq_q, seq_d;
  logic       viol_q, viol_d;
  logic       wake_any;

  assign wake_any   = |wake_i;
  assign state_o    = state_q;
  assign stop_seq_o = seq_q;
  assign abort_o    = seq_q && stpclk_ni;
  assign viol_o     = viol_q;

  always_comb begin
    state_d   = state_q;
    sg_org_d  = sg_org_q;
    snp_org_d = snp_org_q;
    seq_d     = seq_q;
    viol_d    = viol_q;
    unique case (state_q)
      ST_NORMAL, ST_HALT: begin
        if (seq_q) begin
          // hold state while stop-grant entry is pending
          if (stpclk_ni) begin
            viol_d = 1'b1;
            seq_d  = 1'b0;
          end else if (grant_done_i) begin
            state_d  = ST_SG;
            sg_org_d = state_q;
            seq_d    = 1'b0;
          end
        end else if (!stpclk_ni) begin
          seq_d = 1'b1;
        end else if (state_q == ST_NORMAL) begin
          if (halt_req_i) state_d = ST_HALT;
        end else if (wake_any) begin
          state_d = ST_NORMAL;
        end else if (snoop_evt_i) begin
          state_d   = ST_SNOOP;
          snp_org_d = ST_HALT;
        end
      end
      ST_SG: begin
        if (!slp_ni) begin
          state_d = ST_SLEEP;
        end else if (snoop_evt_i) begin
          state_d   = ST_SNOOP;
          snp_org_d = ST_SG;
        end else if (stpclk_ni) begin
          if (sibling_sg_i) state_d = sg_org_q;
          else              viol_d  = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (stpclk_ni) viol_d  = 1'b1;
        if (slp_ni)    state_d = ST_SG;
      end
      ST_SNOOP: begin
        if (stpclk_ni && snp_org_q == ST_SG) viol_d = 1'b1;
        if (snoop_done_i) state_d = snp_org_q;
      end
      default: state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_NORMAL;
      sg_org_q  <= ST_NORMAL;
      snp_org_q <= ST_HALT;
      seq_q     <= 1'b0;
      viol_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      sg_org_q  <= sg_org_d;
      snp_org_q <= snp_org_d;
      seq_q     <= seq_d;
      viol_q    <= viol_d;
    end
  end

  // R4
  sg_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NORMAL || state_q == ST_HALT) && !grant_done_i |=> state_q != ST_SG);

  // R6
  snoop_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SNOOP && snoop_done_i |=> state_q == $past(snp_org_q));

  // R7
  early_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SG && slp_ni && !snoop_evt_i && stpclk_ni && !sibling_sg_i
    |=> state_q == ST_SG && viol_q);

  // R8
  sleep_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SLEEP |=> state_q == ST_SLEEP || state_q == ST_SG);

  // R12
  viol_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_q |=> viol_q);
endmodule

// File: rtl/pwr_flag_decode.sv
module pwr_flag_decode
  import cpu_pwr_pkg::*;
(
  input  pwr_state_e state_i,
  output logic       snoop_ok_o,
  output logic       irq_ok_o
);
  always_comb begin
    snoop_ok_o = 1'b0;
    irq_ok_o   = 1'b0;
    case (state_i)
      ST_HALT, ST_SG: begin
        snoop_ok_o = 1'b1;
        irq_ok_o   = 1'b1;
      end
      ST_SNOOP: snoop_ok_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/cpu_pwr_state_ctrl.sv
module cpu_pwr_state_ctrl
  import cpu_pwr_pkg::*;
#(
  parameter int unsigned GRANT_DELAY = 20,
  parameter int unsigned N_WAKE      = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_req_i,
  input  logic [N_WAKE-1:0] wake_i,
  input  logic              stpclk_ni,
  input  logic              slp_ni,
  input  logic              snoop_evt_i,
  input  logic              snoop_done_i,
  input  logic              sg_ack_rsp_i,
  input  logic              sibling_sg_i,
  output logic [2:0]        state_o,
  output logic              snoop_ok_o,
  output logic              irq_ok_o,
  output logic              viol_o
);
  pwr_state_e state;
  logic       stop_seq;
  logic       abort;
  logic       grant_busy;
  logic       grant_done;

  pwr_grant_timer #(.DELAY(GRANT_DELAY)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (stop_seq && sg_ack_rsp_i),
    .abort_i (abort),
    .busy_o  (grant_busy),
    .done_o  (grant_done)
  );

  pwr_state_fsm #(.N_WAKE(N_WAKE)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .halt_req_i   (halt_req_i),
    .wake_i       (wake_i),
    .stpclk_ni    (stpclk_ni),
    .slp_ni       (slp_ni),
    .snoop_evt_i  (snoop_evt_i),
    .snoop_done_i (snoop_done_i),
    .sibling_sg_i (sibling_sg_i),
    .grant_done_i (grant_done),
    .state_o      (state),
    .stop_seq_o   (stop_seq),
    .abort_o      (abort),
    .viol_o       (viol_o)
  );

  pwr_flag_decode u_flags (
    .state_i    (state),
    .snoop_ok_o (snoop_ok_o),
    .irq_ok_o   (irq_ok_o)
  );

  assign state_o = state;

  // R4
  timer_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_busy |-> stop_seq);

  // R9
  irq_implies_snoop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ok_o |-> snoop_ok_o);
endmodule

// File: tb/cpu_pwr_state_ctrl_tb.sv
`timescale 1ns/1ps
module cpu_pwr_state_ctrl_tb;
  localparam int unsigned D = 5;
  localparam int unsigned NW = 5;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          halt_req = 1'b0;
  logic [NW-1:0] wake = '0;
  logic          stpclk_n = 1'b1;
  logic          slp_n = 1'b1;
  logic          snp_evt = 1'b0;
  logic          snp_done = 1'b0;
  logic          ack = 1'b0;
  logic          sib = 1'b1;
  logic [2:0]    state;
  logic          snoop_ok, irq_ok, viol;
  int            errors = 0;
  int            checks = 0;

  always #2.5 clk = ~clk;

  cpu_pwr_state_ctrl #(.GRANT_DELAY(D), .N_WAKE(NW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .halt_req_i(halt_req), .wake_i(wake),
    .stpclk_ni(stpclk_n), .slp_ni(slp_n), .snoop_evt_i(snp_evt),
    .snoop_done_i(snp_done), .sg_ack_rsp_i(ack), .sibling_sg_i(sib),
    .state_o(state), .snoop_ok_o(snoop_ok), .irq_ok_o(irq_ok), .viol_o(viol)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; stpclk_n = 1'b1; slp_n = 1'b1; sib = 1'b1;
    step(); rst_ni = 1'b1; step();
  endtask

  task automatic pulse_halt(); halt_req = 1'b1; step(); halt_req = 1'b0; endtask
  task automatic pulse_snoop(); snp_evt = 1'b1; step(); snp_evt = 1'b0; endtask
  task automatic pulse_done(); snp_done = 1'b1; step(); snp_done = 1'b0; endtask

  // drive stop-clock and ack, check each cycle of the wait
  task automatic enter_sg(input int org, input string req);
    stpclk_n = 1'b0; step();
    ack = 1'b1; step(); ack = 1'b0;
    for (int k = 1; k <= int'(D); k++) begin
      step();
      chk(req, state, (k == int'(D)) ? 3 : org);
    end
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step();
    // R1 reset state
    chk("R1 state", state, 1); chk("R1 viol", viol, 0);
    chk("R9 snoop_ok normal", snoop_ok, 0); chk("R9 irq_ok normal", irq_ok, 0);
    rst_ni = 1'b1; step();

    // R2
    pulse_halt(); chk("R2 halt", state, 2);
    chk("R9 snoop_ok halt", snoop_ok, 1); chk("R9 irq_ok halt", irq_ok, 1);

    // R3 sweep each wake bit
    for (int i = 0; i < int'(NW); i++) begin
      wake = NW'(1) << i; step(); wake = '0;
      chk($sformatf("R3 wake bit %0d", i), state, 1);
      pulse_halt(); chk("R2 halt again", state, 2);
    end
    wake = '1; step(); wake = '0; chk("R3 all wakes", state, 1);

    // R4 ack with no stop request ignored
    ack = 1'b1; step(); ack = 1'b0;
    stpclk_n = 1'b0;
    for (int k = 0; k < int'(D) + 3; k++) step();
    chk("R4 stale ack ignored", state, 1);
    ack = 1'b1; step(); ack = 1'b0;
    for (int k = 1; k <= int'(D); k++) begin
      step(); chk("R4 delay from normal", state, (k == int'(D)) ? 3 : 1);
    end
    chk("R9 snoop_ok sg", snoop_ok, 1); chk("R9 irq_ok sg", irq_ok, 1);
    // R5 release to normal
    stpclk_n = 1'b1; step();
    chk("R5 release to normal", state, 1); chk("R5 no viol", viol, 0);

    // halt origin path
    pulse_halt(); chk("R2 halt", state, 2);
    enter_sg(2, "R4 delay from halt");
    wake = 5'b10101; step(); wake = '0;
    chk("R10 wake in sg ignored", state, 3);
    slp_n = 1'b0; step(); chk("R8 sleep", state, 5);
    chk("R9 snoop_ok sleep", snoop_ok, 0); chk("R9 irq_ok sleep", irq_ok, 0);
    pulse_snoop(); chk("R8 snoop in sleep ignored", state, 5);
    wake = '1; step(); wake = '0; chk("R10 wake in sleep ignored", state, 5);
    slp_n = 1'b1; step(); chk("R8 sleep release", state, 3);
    pulse_snoop(); chk("R6 snoop from sg", state, 4);
    chk("R9 snoop_ok snoop", snoop_ok, 1); chk("R9 irq_ok snoop", irq_ok, 0);
    step(); chk("R6 snoop held", state, 4);
    pulse_done(); chk("R6 return to sg", state, 3);
    stpclk_n = 1'b1; step(); chk("R5 release to halt", state, 2);
    step(); step(); chk("R10 no stored wake", state, 2);
    chk("R12 clean run viol", viol, 0);
    pulse_snoop(); chk("R6 snoop from halt", state, 4);
    pulse_done(); chk("R6 return to halt", state, 2);

    // R7 sibling not ready
    stpclk_n = 1'b0; step(); ack = 1'b1; step(); ack = 1'b0;
    for (int k = 0; k < int'(D); k++) step();
    chk("R4 sg from halt", state, 3);
    sib = 1'b0; stpclk_n = 1'b1; step(); step();
    chk("R7 stay sg", state, 3); chk("R7 viol", viol, 1);
    sib = 1'b1; step(); chk("R5 late sibling release", state, 2);
    for (int k = 0; k < 4; k++) step();
    chk("R12 sticky", viol, 1);

    // R1 async reset from sleep
    do_reset();
    enter_sg(1, "R4 delay second run");
    slp_n = 1'b0; step(); chk("R8 sleep", state, 5);
    #1 rst_ni = 1'b0; #1;
    chk("R1 async reset state", state, 1); chk("R1 viol clear", viol, 0);
    slp_n = 1'b1; stpclk_n = 1'b1;
    step(); rst_ni = 1'b1; step();

    // R11 release during wait
    stpclk_n = 1'b0; step(); ack = 1'b1; step(); ack = 1'b0;
    step(); step();
    stpclk_n = 1'b1; step();
    chk("R11 viol", viol, 1); chk("R11 state", state, 1);
    for (int k = 0; k < int'(D) + 2; k++) step();
    chk("R11 wait abandoned", state, 1);

    // R11 release before ack
    do_reset();
    pulse_halt();
    stpclk_n = 1'b0; step(); step();
    stpclk_n = 1'b1; step();
    chk("R11 early viol", viol, 1); chk("R11 early state", state, 2);

    // R8 release in sleep
    do_reset();
    enter_sg(1, "R4 delay third run");
    slp_n = 1'b0; step(); stpclk_n = 1'b1; step();
    chk("R8 release in sleep viol", viol, 1); chk("R8 still sleep", state, 5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule